// File: doc/BRIEF.md
# Load alignment and merge unit

This block sits on the load return path. It lies between a doubleword-wide memory read port and the register file write port. Each load presents four things on one strobe cycle: the low address bits, the access size, the signed or unsigned choice and the byte order. The block then does one of two jobs. It can pull the addressed field out of the aligned memory doubleword and widen it to a full register. Or, for the two partial doubleword loads, it can shift the reachable bytes into one end of the register and keep the destination's old bytes everywhere else.

The block also checks natural alignment for ordinary loads. When an ordinary load is misaligned, it raises an address-error flag and withholds the register write. The partial loads are exempt from this check, because they exist precisely to assemble an unaligned doubleword in two steps. The result appears one clock after the strobe.

Top module: `load_align_unit`

## Requirements
- R1: Each cycle with `req_valid` high produces `wb_valid` high on the next cycle. A cycle without `req_valid` produces `wb_valid`, `wb_we` and `wb_err` low on the next cycle, and `wb_data` keeps its previous value.
- R2: For an ordinary load (`req_partial`=0), the size codes are 0 byte, 1 halfword, 2 word and 3 doubleword. `wb_err` rises when `req_addr` is not a multiple of the access size. A byte access never errs.
- R3: When `wb_err` is high, `wb_we` is low and `wb_data` equals the `rd_old` value presented with the request.
- R4: A partial load (`req_partial`=1) never raises `wb_err`, always writes, and ignores `req_size` and `req_unsigned`.
- R5: Memory byte at offset k sits in `mem_rdata[8k+7:8k]` when `req_big_end`=0, and in `mem_rdata[8(7-k)+7:8(7-k)]` when `req_big_end`=1. In an ordinary load, the lowest-addressed byte is least significant in little-endian order and most significant in big-endian order.
- R6: A signed (`req_unsigned`=0) byte, halfword or word load copies the field's top bit into every register bit above the field.
- R7: An unsigned byte, halfword or word load fills every register bit above the field with zero. An unsigned word places the word in bits 31:0 and zeros bits 63:32.
- R8: A left partial load (`req_left`=1) writes the most-significant register bytes. The addressed byte goes to register byte 7. In big-endian order the following bytes come from increasing addresses up to offset 7. In little-endian order they come from decreasing addresses down to offset 0.
- R9: A right partial load (`req_left`=0) writes the least-significant register bytes. The addressed byte goes to register byte 0. In little-endian order the following bytes come from increasing addresses up to offset 7. In big-endian order they come from decreasing addresses down to offset 0.
- R10: In a partial load, every register byte not filled from the aligned doubleword keeps its `rd_old` value.
- R11: While reset is held, `wb_valid`, `wb_we`, `wb_err` and `wb_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | 3 | Byte offset of the effective address within the doubleword |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 doubleword) |
| req_unsigned | input | 1 | Zero-extend instead of sign-extend |
| req_partial | input | 1 | Selects a partial (left/right) doubleword load |
| req_left | input | 1 | Partial direction: 1 left, 0 right |
| req_big_end | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| mem_rdata | input | 64 | Aligned memory doubleword |
| rd_old | input | 64 | Current destination register value |
| wb_valid | output | 1 | Result valid |
| wb_we | output | 1 | Register write enable |
| wb_err | output | 1 | Address-error flag |
| wb_data | output | 64 | Register write value |

## Verification
The bench builds the unit at its default 64-bit width. At that width the offset space is only eight values and there are only four sizes. A directed sweep can therefore cover every offset, size, sign choice and byte order, for ordinary loads and for both partial directions. That sweep includes every misaligned combination and the edge offsets 0 and 7, where a partial load touches one byte or all eight. A long run of random requests with idle gaps then follows. It compares every output on every clock against a byte-array reference model.

// File: rtl/lam_pkg.sv
package lam_pkg;

    // Access size codes: the byte count is two raised to the code
    typedef enum logic [1:0] {
        LAM_BYTE  = 2'd0,
        LAM_HALF  = 2'd1,
        LAM_WORD  = 2'd2,
        LAM_DWORD = 2'd3
    } lam_size_e;

    localparam int unsigned LAM_BYTE_BITS = 8;

endpackage

// File: rtl/lam_align_check.sv
module lam_align_check #(
    parameter int AW = 3,
    parameter int SW = 2
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    input  logic          partial,
    output logic          misaligned
);

    logic [AW-1:0] low_mask;

    always_comb begin
        // Offset bits below the access size must all be zero
        low_mask   = ~({AW{1'b1}} << size);
        misaligned = !partial && (|(addr & low_mask));
    end

endmodule

// File: rtl/lam_extract.sv
module lam_extract #(
    parameter int DW = 64,
    localparam int NB = DW / 8,
    localparam int AW = $clog2(NB),
    localparam int SW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    input  logic          unsigned_ld,
    input  logic          big_end,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] result
);

    logic [AW:0]   span;
    logic [AW:0]   start;
    logic [DW-1:0] field;
    logic          fill;

    always_comb begin
        span  = (AW+1)'(1) << size;
        // Big-endian fields start counting lanes from the top of the word
        start = big_end ? ((AW+1)'(NB) - {1'b0, addr} - span) : {1'b0, addr};
        field = mem_rdata >> {start, 3'b000};
        fill  = !unsigned_ld && field[{span, 3'b000} - 1'b1];
    end

    for (genvar j = 0; j < NB; j++) begin : g_byte
        assign result[8*j +: 8] = ((AW+1)'(j) < span) ? field[8*j +: 8] : {8{fill}};
    end

endmodule

// File: rtl/lam_partial_merge.sv
module lam_partial_merge #(
    parameter int DW = 64,
    localparam int NB = DW / 8,
    localparam int AW = $clog2(NB)
) (
    input  logic [AW-1:0] addr,
    input  logic          left,
    input  logic          big_end,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] rd_old,
    output logic [DW-1:0] result
);

    logic [AW-1:0] amt;
    logic [DW-1:0] shifted;

    always_comb begin
        // Left/big and right/little shift by the offset; the other two by its complement
        amt     = (left == big_end) ? addr : (AW'(NB - 1) - addr);
        shifted = left ? (mem_rdata << {amt, 3'b000}) : (mem_rdata >> {amt, 3'b000});
    end

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic take;
        assign take = left ? (AW'(j) >= amt) : (AW'(j) <= (AW'(NB - 1) - amt));
        assign result[8*j +: 8] = take ? shifted[8*j +: 8] : rd_old[8*j +: 8];
    end

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit #(
    parameter int DW = 64,
    localparam int NB = DW / 8,
    localparam int AW = $clog2(NB),
    localparam int SW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_size,
    input  logic          req_unsigned,
    input  logic          req_partial,
    input  logic          req_left,
    input  logic          req_big_end,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] rd_old,
    output logic          wb_valid,
    output logic          wb_we,
    output logic          wb_err,
    output logic [DW-1:0] wb_data
);

    typedef struct packed {
        logic          valid;
        logic          we;
        logic          err;
        logic [DW-1:0] data;
    } wb_state_t;

    wb_state_t     st_d, st_q;
    logic          misaligned;
    logic [DW-1:0] extracted;
    logic [DW-1:0] merged;

    lam_align_check #(.AW(AW), .SW(SW)) u_align (
        .addr       (req_addr),
        .size       (req_size),
        .partial    (req_partial),
        .misaligned (misaligned)
    );

    lam_extract #(.DW(DW)) u_extract (
        .addr        (req_addr),
        .size        (req_size),
        .unsigned_ld (req_unsigned),
        .big_end     (req_big_end),
        .mem_rdata   (mem_rdata),
        .result      (extracted)
    );

    lam_partial_merge #(.DW(DW)) u_merge (
        .addr      (req_addr),
        .left      (req_left),
        .big_end   (req_big_end),
        .mem_rdata (mem_rdata),
        .rd_old    (rd_old),
        .result    (merged)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        st_d.we    = 1'b0;
        st_d.err   = 1'b0;
        if (req_valid) begin
            st_d.err = misaligned;
            st_d.we  = !misaligned;
            if (misaligned)
                st_d.data = rd_old;
            else if (req_partial)
                st_d.data = merged;
            else
                st_d.data = extracted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wb_valid = st_q.valid;
    assign wb_we    = st_q.we;
    assign wb_err   = st_q.err;
    assign wb_data  = st_q.data;

endmodule

// File: rtl/lam_checker.sv
module lam_checker #(
    parameter int DW = 64,
    localparam int NB = DW / 8,
    localparam int AW = $clog2(NB),
    localparam int SW = $clog2(AW + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [SW-1:0] req_size,
    input logic          req_unsigned,
    input logic          req_partial,
    input logic [DW-1:0] rd_old,
    input logic          wb_valid,
    input logic          wb_we,
    input logic          wb_err,
    input logic [DW-1:0] wb_data
);
    import lam_pkg::*;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> wb_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wb_valid && !wb_we && !wb_err)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(wb_data)); // R1
    AST_BYTE_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_partial && req_size == SW'(LAM_BYTE)) |=> !wb_err); // R2
    AST_ODD_HALF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_partial && req_size == SW'(LAM_HALF) && req_addr[0]) |=> wb_err); // R2
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> !wb_we); // R3
    AST_ERR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_partial && req_size == SW'(LAM_WORD) && req_addr[1:0] != 2'b00)
        |=> (wb_data == $past(rd_old))); // R3
    AST_PARTIAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_partial) |=> (!wb_err && wb_we)); // R4
    AST_UBYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_partial && req_unsigned && req_size == SW'(LAM_BYTE))
        |=> (wb_data[DW-1:8] == '0)); // R7

endmodule

bind load_align_unit lam_checker #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .req_partial  (req_partial),
    .rd_old       (rd_old),
    .wb_valid     (wb_valid),
    .wb_we        (wb_we),
    .wb_err       (wb_err),
    .wb_data      (wb_data)
);

// File: tb/sim_load_align_unit.sv
module sim_load_align_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_unsigned = 1'b0;
    logic        req_partial = 1'b0;
    logic        req_left = 1'b0;
    logic        req_big_end = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [63:0] rd_old = '0;
    logic        wb_valid, wb_we, wb_err;
    logic [63:0] wb_data;

    load_align_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Reference state after the next clock edge
    logic        e_valid = 1'b0, e_we = 1'b0, e_err = 1'b0, e_part = 1'b0;
    logic [63:0] e_data = '0;
    string       e_tag = "R11";

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Byte-array reference: index mb[] by byte address within the doubleword
    function automatic logic [64:0] model(input int a, input int sz, input bit uns, input bit part,
                                          input bit left, input bit be, input logic [63:0] mem,
                                          input logic [63:0] old);
        logic [7:0]  mb [8];
        logic [63:0] r;
        int          n;
        logic        sgn;
        for (int k = 0; k < 8; k++) mb[k] = be ? mem[8*(7-k) +: 8] : mem[8*k +: 8];
        if (!part) begin
            n = 1 << sz;
            if ((a % n) != 0) return {1'b1, old};
            r = '0;
            for (int i = 0; i < n; i++) r[8*(be ? n-1-i : i) +: 8] = mb[a+i];
            sgn = !uns && r[8*n-1];
            for (int j = n; j < 8; j++) r[8*j +: 8] = {8{sgn}};
            return {1'b0, r};
        end
        r = old;
        if (left) begin
            if (be) for (int i = 0; i <= 7-a; i++) r[8*(7-i) +: 8] = mb[a+i];
            else    for (int i = 0; i <= a; i++)   r[8*(7-i) +: 8] = mb[a-i];
        end else begin
            if (be) for (int i = 0; i <= a; i++)   r[8*i +: 8] = mb[a-i];
            else    for (int i = 0; i <= 7-a; i++) r[8*i +: 8] = mb[a+i];
        end
        return {1'b0, r};
    endfunction

    task automatic compare(input string vtag);
        check(vtag, "wb_valid", 64'(wb_valid), 64'(e_valid));
        check(e_part ? "R4" : "R2", "wb_err", 64'(wb_err), 64'(e_err));
        check("R3", "wb_we", 64'(wb_we), 64'(e_we));
        check(e_tag, "wb_data", wb_data, e_data);
    endtask

    task automatic step(input bit v, input int a, input int sz, input bit uns, input bit part,
                        input bit left, input bit be, input logic [63:0] mem, input logic [63:0] old);
        logic [64:0] res;
        @(negedge clk);
        compare("R1");
        req_valid = v; req_addr = 3'(a); req_size = 2'(sz); req_unsigned = uns;
        req_partial = part; req_left = left; req_big_end = be; mem_rdata = mem; rd_old = old;
        if (v) begin
            res     = model(a, sz, uns, part, left, be, mem, old);
            e_valid = 1'b1; e_err = res[64]; e_we = !res[64]; e_data = res[63:0]; e_part = part;
            if (res[64])   e_tag = "R3";
            else if (part) e_tag = left ? "R8,R10" : "R9,R10";
            else           e_tag = uns ? "R5,R7" : "R5,R6";
        end else begin
            e_valid = 1'b0; e_err = 1'b0; e_we = 1'b0; e_part = 1'b0; e_tag = "R1";
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    localparam logic [63:0] PAT_A = 64'h8877_6655_4433_2211;
    localparam logic [63:0] PAT_B = 64'h0F1E_2D3C_4B5A_6978;
    localparam logic [63:0] OLD_A = 64'hAAAA_BBBB_CCCC_DDDD;

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        compare("R11");
        rst_n = 1'b1;
        // Ordinary loads: every offset, size, sign choice and byte order (R2 R5 R6 R7)
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 4; sz++)
                for (int a = 0; a < 8; a++)
                    for (int u = 0; u < 2; u++)
                        step(1, a, sz, u[0], 0, 0, be[0], (a % 2) ? PAT_B : PAT_A, OLD_A);
        // Idle gap: outputs quiet, data held (R1)
        step(0, 0, 0, 0, 0, 0, 0, PAT_B, 64'h0);
        step(0, 5, 3, 0, 0, 0, 0, PAT_A, 64'h1);
        // Partial loads in both directions; size/sign set to odd values to show they are ignored (R4 R8 R9 R10)
        for (int be = 0; be < 2; be++)
            for (int l = 0; l < 2; l++)
                for (int a = 0; a < 8; a++)
                    step(1, a, (a * 3) % 4, a[0], 1, l[0], be[0], PAT_A, OLD_A);
        // Random traffic with idle cycles
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(3, 0) != 0, $urandom_range(7, 0), $urandom_range(3, 0),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 {$urandom, $urandom}, {$urandom, $urandom});
        end
        step(0, 0, 0, 0, 0, 0, 0, 64'h0, 64'h0);
        @(negedge clk);
        compare("R1");
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule